// File: doc/BRIEF.md
# Dual-Strobe Cascadable Up/Down Counter

This block is a reversible binary counter that counts on two independent strobe inputs, one that adds and one that subtracts. It also has a parallel preset, a clear and two active-low terminal-count outputs. The strobes are ordinary inputs. A free-running system clock samples each one through a synchronizer, and a rising edge seen on a strobe makes one count step. To count with one strobe, the other strobe is held high. When neither strobe rises, the value holds.

The carry output goes low only while the count is all ones and the count-up strobe is low. The borrow output goes low only while the count is zero and the count-down strobe is low. Each terminal-count output therefore repeats the low phase of its strobe at the terminal state. It rises together with the wrapping step, so the outputs of one stage can drive the strobes of the next stage directly and build a wider counter. Clear has top priority and zeroes the count. The active-low load copies the preset data. Both act on the next system clock edge and ignore the strobes.

Top module: `dual_strobe_counter`

## Requirements
- R1: A rising edge on `up_stb_i` with no rising edge on `dn_stb_i`, seen while `clear_i` is low and `load_n_i` is high, adds one to `count_o`. With a two-stage synchronizer, the new value appears on the third system clock edge after the strobe changes.
- R2: Under the same conditions, a rising edge on `dn_stb_i` alone subtracts one from `count_o`.
- R3: The count wraps in plain binary. All ones plus one gives zero, and zero minus one gives all ones.
- R4: While neither strobe has a rising edge, `count_o` keeps its value. This includes a strobe held low for any length of time.
- R5: `clear_i` (active high) has top priority. On the next edge it sets `count_o` to zero and overrides the load input and both strobes. After clear, `carry_n_o` and `borrow_n_o` are high and `clash_o` is low.
- R6: While `clear_i` is low, `load_n_i` low makes `count_o` equal `data_i` on the next edge, whatever the strobes are doing.
- R7: `carry_n_o` is low exactly when `count_o` is all ones and the synchronized count-up strobe is low. Otherwise it is high.
- R8: `borrow_n_o` is low exactly when `count_o` is zero and the synchronized count-down strobe is low. Otherwise it is high.
- R9: A strobe that is low during a clear or load, and stays low afterwards, counts once on its next rising edge.
- R10: A rising strobe edge detected in a cycle where clear or load is active is discarded. The count takes the cleared or loaded value and nothing more.
- R11: Rising edges on both strobes in the same system cycle leave `count_o` unchanged and drive `clash_o` high for exactly one cycle.
- R12: When the carry and borrow outputs of one instance drive the up and down strobes of a second instance, the pair forms an 8-bit counter. The 8-bit value follows a reference counter through up and down counting, 8-bit wrap, preset and clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| clear_i | input | 1 | Clear, active high, highest priority |
| load_n_i | input | 1 | Parallel preset, active low |
| data_i | input | W | Preset value |
| up_stb_i | input | 1 | Count-up strobe, counts on its rising edge |
| dn_stb_i | input | 1 | Count-down strobe, counts on its rising edge |
| count_o | output | W | Current count |
| carry_n_o | output | 1 | Active-low carry, follows the up strobe low phase at all ones |
| borrow_n_o | output | 1 | Active-low borrow, follows the down strobe low phase at zero |
| clash_o | output | 1 | One-cycle pulse when both strobes rise together |

## Verification
The hardest situation to create is a carry or borrow transition in the first stage that must reach the second stage as a clean single edge. It only happens when the low stage sits at its terminal value while its strobe is low. The bench presets the chained pair to values such as 0x0F, 0x20 and 0xFE, then pulses a single strobe slowly enough for both synchronizer chains to settle. Two further cases need strobe rises timed against the control inputs. For the discard case, a strobe rise is placed inside a held load or clear. For the clash case, both strobes are released on the same clock phase after a preset has moved the low stage away from its terminal values.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_UP,
    OP_DN,
    OP_CLR,
    OP_LOAD,
    OP_CLASH
  } udc_op_e;
endpackage

// File: rtl/udc_strobe_sync.sv
module udc_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic clear_i,
  input  logic strobe_i,
  output logic lvl_o,
  output logic lvl_next_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  // Synchronizer chain, parked high (idle) while cleared
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (clear_i) chain[0] <= 1'b1;
        else         chain[0] <= strobe_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i) begin
        if (clear_i) chain[g] <= 1'b1;
        else         chain[g] <= chain[g-1];
      end
    end
  end

  // Value the last stage takes on the coming edge
  if (STAGES == 1) begin : g_next_direct
    assign lvl_next_o = strobe_i;
  end else begin : g_next_chain
    assign lvl_next_o = chain[STAGES-2];
  end

  always_ff @(posedge clk_i) begin
    if (clear_i) prev_q <= 1'b1;
    else         prev_q <= chain[STAGES-1];
  end

  assign lvl_o  = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/udc_count_core.sv
module udc_count_core
  import udc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         clear_i,
  input  logic         load_n_i,
  input  logic [W-1:0] data_i,
  input  logic         up_rise_i,
  input  logic         dn_rise_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] count_next_o,
  output logic         clash_o
);
  localparam logic [W-1:0] ONE = W'(1);

  udc_op_e      op;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         clash_q;

  // Priority: clear, load, simultaneous edges, single edges
  always_comb begin
    op = OP_HOLD;
    if (clear_i)                     op = OP_CLR;
    else if (!load_n_i)              op = OP_LOAD;
    else if (up_rise_i && dn_rise_i) op = OP_CLASH;
    else if (up_rise_i)              op = OP_UP;
    else if (dn_rise_i)              op = OP_DN;
  end

  always_comb begin
    case (op)
      OP_CLR:  cnt_d = '0;
      OP_LOAD: cnt_d = data_i;
      OP_UP:   cnt_d = cnt_q + ONE;
      OP_DN:   cnt_d = cnt_q - ONE;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    cnt_q   <= cnt_d;
    clash_q <= (op == OP_CLASH);
  end

  assign count_o      = cnt_q;
  assign count_next_o = cnt_d;
  assign clash_o      = clash_q;
endmodule

// File: rtl/udc_term_detect.sv
module udc_term_detect #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         clear_i,
  input  logic [W-1:0] count_next_i,
  input  logic         up_next_i,
  input  logic         dn_next_i,
  output logic         carry_n_o,
  output logic         borrow_n_o
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic carry_q;
  logic borrow_q;

  // Registered from next-state values so outputs align with count and strobe level
  always_ff @(posedge clk_i) begin
    if (clear_i) begin
      carry_q  <= 1'b1;
      borrow_q <= 1'b1;
    end else begin
      carry_q  <= ~((count_next_i == ALL_ONES) & ~up_next_i);
      borrow_q <= ~((count_next_i == '0)       & ~dn_next_i);
    end
  end

  assign carry_n_o  = carry_q;
  assign borrow_n_o = borrow_q;
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         clear_i,
  input  logic         load_n_i,
  input  logic [W-1:0] data_i,
  input  logic         up_stb_i,
  input  logic         dn_stb_i,
  output logic [W-1:0] count_o,
  output logic         carry_n_o,
  output logic         borrow_n_o,
  output logic         clash_o
);
  localparam int NSTB = 2;

  logic [NSTB-1:0] stb_raw;
  logic [NSTB-1:0] stb_lvl;
  logic [NSTB-1:0] stb_next;
  logic [NSTB-1:0] stb_rise;
  logic            up_rise;
  logic            dn_rise;
  logic            up_lvl;
  logic            dn_lvl;
  logic [W-1:0]    count_next;

  assign stb_raw = {dn_stb_i, up_stb_i};

  for (genvar s = 0; s < NSTB; s++) begin : g_sync
    udc_strobe_sync #(.STAGES(STAGES)) u_sync (
      .clk_i      (clk_i),
      .clear_i    (clear_i),
      .strobe_i   (stb_raw[s]),
      .lvl_o      (stb_lvl[s]),
      .lvl_next_o (stb_next[s]),
      .rise_o     (stb_rise[s])
    );
  end

  assign up_rise = stb_rise[0];
  assign dn_rise = stb_rise[1];
  assign up_lvl  = stb_lvl[0];
  assign dn_lvl  = stb_lvl[1];

  udc_count_core #(.W(W)) u_core (
    .clk_i        (clk_i),
    .clear_i      (clear_i),
    .load_n_i     (load_n_i),
    .data_i       (data_i),
    .up_rise_i    (up_rise),
    .dn_rise_i    (dn_rise),
    .count_o      (count_o),
    .count_next_o (count_next),
    .clash_o      (clash_o)
  );

  udc_term_detect #(.W(W)) u_term (
    .clk_i        (clk_i),
    .clear_i      (clear_i),
    .count_next_i (count_next),
    .up_next_i    (stb_next[0]),
    .dn_next_i    (stb_next[1]),
    .carry_n_o    (carry_n_o),
    .borrow_n_o   (borrow_n_o)
  );
endmodule

// File: rtl/udc_checker.sv
module udc_checker #(
  parameter int W = 4
) (
  input logic         clk_i,
  input logic         clear_i,
  input logic         load_n_i,
  input logic [W-1:0] data_i,
  input logic [W-1:0] count_o,
  input logic         carry_n_o,
  input logic         borrow_n_o,
  input logic         clash_o,
  input logic         up_rise,
  input logic         dn_rise,
  input logic         up_lvl,
  input logic         dn_lvl
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = W'(1);

  logic clr_seen_q = 1'b0;

  always_ff @(posedge clk_i) clr_seen_q <= clear_i;

  // R5: a clear on the previous edge leaves zero and idle flags
  always @(negedge clk_i) begin
    if (clr_seen_q) begin
      assert_clear_zero_R5: assert (count_o == '0 && carry_n_o && borrow_n_o && !clash_o);
    end
  end

  assert_up_step_R1: assert property (@(posedge clk_i) disable iff (clear_i)
    load_n_i && up_rise && !dn_rise |=> count_o == $past(count_o) + ONE);

  assert_down_step_R2: assert property (@(posedge clk_i) disable iff (clear_i)
    load_n_i && dn_rise && !up_rise |=> count_o == $past(count_o) - ONE);

  assert_wrap_up_R3: assert property (@(posedge clk_i) disable iff (clear_i)
    load_n_i && up_rise && !dn_rise && count_o == ALL_ONES |=> count_o == '0);

  assert_wrap_down_R3: assert property (@(posedge clk_i) disable iff (clear_i)
    load_n_i && dn_rise && !up_rise && count_o == '0 |=> count_o == ALL_ONES);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (clear_i)
    load_n_i && !up_rise && !dn_rise |=> $stable(count_o));

  // R6 and R10: load wins over any detected edge
  assert_load_copy_R6: assert property (@(posedge clk_i) disable iff (clear_i)
    !load_n_i |=> count_o == $past(data_i));

  assert_carry_R7: assert property (@(posedge clk_i) disable iff (clear_i)
    carry_n_o == !(count_o == ALL_ONES && !up_lvl));

  assert_borrow_R8: assert property (@(posedge clk_i) disable iff (clear_i)
    borrow_n_o == !(count_o == '0 && !dn_lvl));

  assert_clash_R11: assert property (@(posedge clk_i) disable iff (clear_i)
    load_n_i && up_rise && dn_rise |=> clash_o && $stable(count_o));

  assert_clash_quiet_R11: assert property (@(posedge clk_i) disable iff (clear_i)
    !(load_n_i && up_rise && dn_rise) |=> !clash_o);
endmodule

bind dual_strobe_counter udc_checker #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .clear_i    (clear_i),
  .load_n_i   (load_n_i),
  .data_i     (data_i),
  .count_o    (count_o),
  .carry_n_o  (carry_n_o),
  .borrow_n_o (borrow_n_o),
  .clash_o    (clash_o),
  .up_rise    (up_rise),
  .dn_rise    (dn_rise),
  .up_lvl     (up_lvl),
  .dn_lvl     (dn_lvl)
);

// File: tb/dual_strobe_counter_tb.sv
`timescale 1ns/1ps
module dual_strobe_counter_tb;
  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       load_n = 1'b1;
  logic       up = 1'b1;
  logic       dn = 1'b1;
  logic [7:0] pre = 8'h00;
  logic [3:0] lo_cnt, hi_cnt;
  logic       lo_carry, lo_borrow, lo_clash;
  logic       hi_carry, hi_borrow, hi_clash;
  logic [7:0] ref_cnt = 8'h00;
  int         nchk = 0;
  int         nfail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  dual_strobe_counter u_dut (
    .clk_i(clk), .clear_i(clear), .load_n_i(load_n), .data_i(pre[3:0]),
    .up_stb_i(up), .dn_stb_i(dn), .count_o(lo_cnt),
    .carry_n_o(lo_carry), .borrow_n_o(lo_borrow), .clash_o(lo_clash));

  dual_strobe_counter u_hi (
    .clk_i(clk), .clear_i(clear), .load_n_i(load_n), .data_i(pre[7:4]),
    .up_stb_i(lo_carry), .dn_stb_i(lo_borrow), .count_o(hi_cnt),
    .carry_n_o(hi_carry), .borrow_n_o(hi_borrow), .clash_o(hi_clash));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic up_pulse;
    up = 1'b0; wait_n(8); up = 1'b1; wait_n(8); ref_cnt = ref_cnt + 8'd1;
  endtask

  task automatic dn_pulse;
    dn = 1'b0; wait_n(8); dn = 1'b1; wait_n(8); ref_cnt = ref_cnt - 8'd1;
  endtask

  task automatic do_load(input logic [7:0] v);
    pre = v; load_n = 1'b0; wait_n(4); load_n = 1'b1; wait_n(8); ref_cnt = v;
  endtask

  task automatic do_clear;
    clear = 1'b1; wait_n(4); clear = 1'b0; wait_n(8); ref_cnt = 8'h00;
  endtask

  task automatic t_reset;
    chk("R5 count after clear", lo_cnt, 0);
    chk("R5 carry after clear", lo_carry, 1);
    chk("R5 borrow after clear", lo_borrow, 1);
    chk("R5 clash after clear", lo_clash, 0);
  endtask

  task automatic t_up;
    do_clear();
    for (int i = 0; i < 20; i++) begin
      up_pulse();
      chk("R1 up step", lo_cnt, int'(ref_cnt[3:0]));
      chk("R12 cascade up", {hi_cnt, lo_cnt}, int'(ref_cnt));
      if (i == 15) chk("R3 wrap up to zero", lo_cnt, 0);
    end
  endtask

  task automatic t_down;
    do_load(8'h12);
    for (int i = 0; i < 20; i++) begin
      dn_pulse();
      chk("R2 down step", lo_cnt, int'(ref_cnt[3:0]));
      chk("R12 cascade down", {hi_cnt, lo_cnt}, int'(ref_cnt));
      if (i == 2) chk("R3 wrap down to all ones", lo_cnt, 15);
    end
  endtask

  task automatic t_wrap8;
    do_load(8'hFE);
    repeat (3) up_pulse();
    chk("R12 8-bit wrap up", {hi_cnt, lo_cnt}, 8'h01);
    repeat (3) dn_pulse();
    chk("R12 8-bit wrap down", {hi_cnt, lo_cnt}, 8'hFE);
  endtask

  task automatic t_carry;
    do_load(8'h0F);
    chk("R7 carry high with strobe high", lo_carry, 1);
    up = 1'b0; wait_n(8);
    chk("R7 carry low at all ones", lo_carry, 0);
    chk("R8 borrow high at all ones", lo_borrow, 1);
    up = 1'b1; wait_n(8); ref_cnt = 8'h10;
    chk("R7 carry released", lo_carry, 1);
    chk("R12 carry into high stage", {hi_cnt, lo_cnt}, int'(ref_cnt));
  endtask

  task automatic t_borrow;
    do_load(8'h20);
    chk("R8 borrow high with strobe high", lo_borrow, 1);
    dn = 1'b0; wait_n(8);
    chk("R8 borrow low at zero", lo_borrow, 0);
    chk("R7 carry high at zero", lo_carry, 1);
    dn = 1'b1; wait_n(8); ref_cnt = 8'h1F;
    chk("R8 borrow released", lo_borrow, 1);
    chk("R12 borrow from high stage", {hi_cnt, lo_cnt}, int'(ref_cnt));
  endtask

  task automatic t_load;
    do_load(8'hA7);
    chk("R6 load A7", {hi_cnt, lo_cnt}, 8'hA7);
    do_load(8'h3C);
    chk("R6 load 3C", {hi_cnt, lo_cnt}, 8'h3C);
  endtask

  task automatic t_discard;
    do_load(8'h05);
    up = 1'b0; wait_n(8);
    pre = 8'h09; load_n = 1'b0; wait_n(2); up = 1'b1; wait_n(6);
    load_n = 1'b1; wait_n(8);
    chk("R10 edge during load discarded", {hi_cnt, lo_cnt}, 8'h09);
    up = 1'b0; wait_n(8);
    clear = 1'b1; wait_n(2); up = 1'b1; wait_n(6);
    clear = 1'b0; wait_n(8);
    chk("R10 edge during clear discarded", {hi_cnt, lo_cnt}, 8'h00);
  endtask

  task automatic t_low_through;
    do_load(8'h05);
    up = 1'b0; wait_n(4);
    clear = 1'b1; wait_n(4); clear = 1'b0; wait_n(8);
    chk("R9 clear with up low", lo_cnt, 0);
    up = 1'b1; wait_n(8);
    chk("R9 first rise after clear counts", {hi_cnt, lo_cnt}, 8'h01);
    dn = 1'b0; wait_n(4);
    pre = 8'h07; load_n = 1'b0; wait_n(4); load_n = 1'b1; wait_n(8);
    chk("R9 load with down low", lo_cnt, 7);
    dn = 1'b1; wait_n(8);
    chk("R9 first rise after load counts", {hi_cnt, lo_cnt}, 8'h06);
  endtask

  task automatic t_hold;
    do_load(8'h5A);
    wait_n(20);
    chk("R4 hold idle", {hi_cnt, lo_cnt}, 8'h5A);
    up = 1'b0; wait_n(20);
    chk("R4 hold with strobe low", {hi_cnt, lo_cnt}, 8'h5A);
    up = 1'b1; wait_n(8);
    chk("R1 single count after long low", {hi_cnt, lo_cnt}, 8'h5B);
  endtask

  task automatic t_clash;
    do_load(8'h35);
    up = 1'b0; dn = 1'b0; wait_n(8);
    up = 1'b1; dn = 1'b1;
    wait_n(3);
    chk("R11 clash pulse high", lo_clash, 1);
    chk("R11 count unchanged on clash", lo_cnt, 5);
    wait_n(1);
    chk("R11 clash lasts one cycle", lo_clash, 0);
    wait_n(8);
    chk("R11 value after clash", {hi_cnt, lo_cnt}, 8'h35);
  endtask

  initial begin
    wait_n(4);
    clear = 1'b0;
    wait_n(4);
    t_reset();
    t_up();
    t_down();
    t_wrap8();
    t_carry();
    t_borrow();
    t_load();
    t_discard();
    t_low_through();
    t_hold();
    t_clash();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule